// File: doc/BRIEF.md
# Stream-Cipher Keystream Decryption Engine

This engine produces the keystream of an RC4-style cipher from a 256-entry byte permutation that is already shuffled. It decrypts a fixed 32-byte message with that keystream. The permutation sits in a single-port working RAM and the engine updates it in place. Ciphertext bytes come from a 32-entry ROM, and each recovered plaintext byte goes to a separate 32-entry result RAM. Each plaintext byte is also presented on a strobed side stream, so a monitor can follow progress without reading the RAM.

A neighbouring controller fills the working RAM, either through a key schedule or directly. It then pulses `start` and waits for `done`. Every memory behind the engine reads synchronously: read data appears in the cycle after the address is presented. The engine never uses read data before that cycle.

Top module: `rc4x_engine`

## Requirements
- R1: While reset is held and right after it, `done`, `workWrEn`, `plainWrEn` and `byteValid` are all 0.
- R2: A `start` pulse accepted while idle or finished begins a run with both stream indices i and j at 0, whatever earlier runs left behind. A second run over the RAM left by the first therefore matches a model that starts from i=j=0.
- R3: For each output byte the engine does four things in order. It adds 1 to i, adds s[i] to j, exchanges s[i] with s[j], then reads f from s[s[i]+s[j]], taking the two entries after the exchange. All of this uses 8-bit arithmetic that wraps modulo 256.
- R4: Output byte k is f XOR ciphertext[k] and is written to result address k. Each run makes exactly 32 result writes, at addresses 0 to 31 in ascending order.
- R5: Each exchange takes two back-to-back working-RAM write cycles, the first at address i and the second at address j. After a run the working RAM holds the same permutation as the model.
- R6: `done` rises in the cycle after the last result write and stays high until the next accepted `start`. While `done` is high, neither write enable is asserted.
- R7: A `start` pulse that arrives during a run has no effect. The run still makes 32 writes, and the result RAM and working RAM end as if no pulse had come.
- R8: `byteValid` is high in exactly the cycles in which `plainWrEn` is high, and in those cycles `byteOut` equals `plainWrData`.
- R9: Starting from the permutation that the standard key schedule builds from the 3-byte key 0x000249 (key byte 0 = 0x00, byte 1 = 0x02, byte 2 = 0x49), the result RAM matches the software model byte for byte.
- R10: Starting from the identity permutation, the first step exchanges s[1] with itself, because i = j = 1. The entry keeps its value and the outputs match the model.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a run when idle or finished |
| done | output | 1 | Run complete; held until the next start |
| workAddr | output | IDX_W | Working RAM address |
| workWrData | output | IDX_W | Working RAM write data |
| workWrEn | output | 1 | Working RAM write enable |
| workRdData | input | IDX_W | Working RAM read data, one cycle after the address |
| cipherAddr | output | MSG_AW | Ciphertext ROM address |
| cipherRdData | input | IDX_W | Ciphertext ROM read data, one cycle after the address |
| plainAddr | output | MSG_AW | Result RAM address |
| plainWrData | output | IDX_W | Result RAM write data |
| plainWrEn | output | 1 | Result RAM write enable |
| byteValid | output | 1 | Strobe for the plaintext side stream |
| byteOut | output | IDX_W | Plaintext side-stream byte |

## Verification
The assertions assume that `start` is only acted on from the idle or finished state. They also assume each run begins with result index 0 and that the memories answer with exactly one cycle of read latency. The bench's memory models reply one cycle after every address and never stall. The bench raises `start` only as single-cycle pulses, driven on the falling edge, and issues the one pulse that lands mid-run deliberately to exercise R7. Working-RAM contents are only ever loaded while the engine is idle or finished, so the permutation never changes under a run.

// File: rtl/rc4x_pkg.sv
package rc4x_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_INC, ST_RDSI, ST_LDSI, ST_RDSJ, ST_LDSJ,
    ST_WRI, ST_WRJ, ST_RDF, ST_LDF, ST_OUT, ST_DONE
  } engState_e;

  typedef enum logic [1:0] {
    SEL_I, SEL_J, SEL_SUM
  } addrSel_e;

  typedef struct packed {
    logic     clr;
    logic     incI;
    logic     ldSi;
    logic     ldSj;
    logic     ldF;
    logic     incK;
    addrSel_e addrSel;
    logic     wrEn;
    logic     wrSj;
    logic     plainWr;
  } ctrlStrobe_t;

endpackage

// File: rtl/rc4x_ctrl.sv
module rc4x_ctrl
  import rc4x_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        kLast,
  output ctrlStrobe_t strobe,
  output logic        done
);

  engState_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    strobe.addrSel = SEL_I;
    unique case (stateQ)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          strobe.clr = 1'b1;
          stateD = ST_INC;
        end
      end
      ST_INC: begin
        strobe.incI = 1'b1;
        stateD = ST_RDSI;
      end
      ST_RDSI: stateD = ST_LDSI;
      ST_LDSI: begin
        strobe.ldSi = 1'b1;
        stateD = ST_RDSJ;
      end
      ST_RDSJ: begin
        strobe.addrSel = SEL_J;
        stateD = ST_LDSJ;
      end
      ST_LDSJ: begin
        strobe.ldSj = 1'b1;
        stateD = ST_WRI;
      end
      ST_WRI: begin
        strobe.wrEn = 1'b1;
        strobe.wrSj = 1'b1;
        stateD = ST_WRJ;
      end
      ST_WRJ: begin
        strobe.addrSel = SEL_J;
        strobe.wrEn = 1'b1;
        stateD = ST_RDF;
      end
      ST_RDF: begin
        strobe.addrSel = SEL_SUM;
        stateD = ST_LDF;
      end
      ST_LDF: begin
        strobe.ldF = 1'b1;
        stateD = ST_OUT;
      end
      ST_OUT: begin
        strobe.plainWr = 1'b1;
        strobe.incK = 1'b1;
        stateD = kLast ? ST_DONE : ST_INC;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign done = (stateQ == ST_DONE);

endmodule

// File: rtl/rc4x_datapath.sv
module rc4x_datapath
  import rc4x_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int MSG_LEN = 32,
  localparam int MSG_AW = $clog2(MSG_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [IDX_W-1:0]  workRdData,
  input  logic [IDX_W-1:0]  cipherRdData,
  output logic [IDX_W-1:0]  workAddr,
  output logic [IDX_W-1:0]  workWrData,
  output logic              workWrEn,
  output logic [MSG_AW-1:0] cipherAddr,
  output logic [MSG_AW-1:0] plainAddr,
  output logic [IDX_W-1:0]  plainWrData,
  output logic              plainWrEn,
  output logic              byteValid,
  output logic [IDX_W-1:0]  byteOut,
  output logic              kLast
);

  localparam logic [MSG_AW-1:0] K_LAST = MSG_AW'(MSG_LEN - 1);

  logic [IDX_W-1:0]  iIdx, jIdx, siVal, sjVal, fByte, cByte;
  logic [MSG_AW-1:0] kIdx;
  logic [IDX_W-1:0]  sumIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iIdx  <= '0;
      jIdx  <= '0;
      siVal <= '0;
      sjVal <= '0;
      fByte <= '0;
      cByte <= '0;
      kIdx  <= '0;
    end else begin
      if (strobe.clr) begin
        iIdx <= '0;
        jIdx <= '0;
        kIdx <= '0;
      end
      if (strobe.incI) iIdx <= iIdx + 1'b1;
      if (strobe.ldSi) begin
        siVal <= workRdData;
        jIdx  <= jIdx + workRdData;
      end
      if (strobe.ldSj) sjVal <= workRdData;
      if (strobe.ldF) begin
        fByte <= workRdData;
        cByte <= cipherRdData;
      end
      if (strobe.incK) kIdx <= kIdx + 1'b1;
    end
  end

  // After the exchange s[i]=sjVal and s[j]=siVal; the sum is order-free.
  assign sumIdx = siVal + sjVal;

  always_comb begin
    unique case (strobe.addrSel)
      SEL_J:   workAddr = jIdx;
      SEL_SUM: workAddr = sumIdx;
      default: workAddr = iIdx;
    endcase
  end

  assign workWrData  = strobe.wrSj ? sjVal : siVal;
  assign workWrEn    = strobe.wrEn;
  assign cipherAddr  = kIdx;
  assign plainAddr   = kIdx;
  assign plainWrData = fByte ^ cByte;
  assign plainWrEn   = strobe.plainWr;
  assign byteValid   = strobe.plainWr;
  assign byteOut     = fByte ^ cByte;
  assign kLast       = (kIdx == K_LAST);

endmodule

// File: rtl/rc4x_engine.sv
module rc4x_engine
  import rc4x_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int MSG_LEN = 32,
  localparam int MSG_AW = $clog2(MSG_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              done,
  output logic [IDX_W-1:0]  workAddr,
  output logic [IDX_W-1:0]  workWrData,
  output logic              workWrEn,
  input  logic [IDX_W-1:0]  workRdData,
  output logic [MSG_AW-1:0] cipherAddr,
  input  logic [IDX_W-1:0]  cipherRdData,
  output logic [MSG_AW-1:0] plainAddr,
  output logic [IDX_W-1:0]  plainWrData,
  output logic              plainWrEn,
  output logic              byteValid,
  output logic [IDX_W-1:0]  byteOut
);

  ctrlStrobe_t strobe;
  logic        kLast;

  rc4x_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .kLast  (kLast),
    .strobe (strobe),
    .done   (done)
  );

  rc4x_datapath #(.IDX_W(IDX_W), .MSG_LEN(MSG_LEN)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .workRdData   (workRdData),
    .cipherRdData (cipherRdData),
    .workAddr     (workAddr),
    .workWrData   (workWrData),
    .workWrEn     (workWrEn),
    .cipherAddr   (cipherAddr),
    .plainAddr    (plainAddr),
    .plainWrData  (plainWrData),
    .plainWrEn    (plainWrEn),
    .byteValid    (byteValid),
    .byteOut      (byteOut),
    .kLast        (kLast)
  );

endmodule

// File: rtl/rc4x_checker.sv
module rc4x_checker #(
  parameter int IDX_W   = 8,
  parameter int MSG_LEN = 32,
  localparam int MSG_AW = $clog2(MSG_LEN)
) (
  input logic              clk,
  input logic              rstN,
  input logic              done,
  input logic              workWrEn,
  input logic              plainWrEn,
  input logic [MSG_AW-1:0] plainAddr,
  input logic [IDX_W-1:0]  plainWrData,
  input logic              byteValid,
  input logic [IDX_W-1:0]  byteOut
);

  localparam logic [MSG_AW-1:0] LAST_ADDR = MSG_AW'(MSG_LEN - 1);

  logic [MSG_AW:0] expIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          expIdx <= '0;
    else if (done)      expIdx <= '0;
    else if (plainWrEn) expIdx <= expIdx + 1'b1;
  end

  // R4: result writes walk the addresses in ascending order, never past the end
  assert_write_order_R4: assert property (@(posedge clk) disable iff (!rstN)
    plainWrEn |-> (expIdx < (MSG_AW+1)'(MSG_LEN)) && ({1'b0, plainAddr} == expIdx));

  // R6: done rises only right after the final result write
  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(plainWrEn) && ($past(plainAddr) == LAST_ADDR));

  // R6: a finished engine is quiet on both memories
  assert_quiet_when_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !workWrEn && !plainWrEn);

  // R5: an exchange is two back-to-back writes, never one and never three
  assert_swap_pair_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(workWrEn) |=> workWrEn);
  assert_swap_len_R5: assert property (@(posedge clk) disable iff (!rstN)
    (workWrEn && $past(workWrEn)) |=> !workWrEn);

  // R8: the side stream mirrors each result write
  assert_stream_mirror_R8: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid == plainWrEn) && (!byteValid || (byteOut == plainWrData)));

  // R5/R4: the two memories are never written in the same cycle
  assert_one_writer_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(workWrEn && plainWrEn));

endmodule

bind rc4x_engine rc4x_checker #(.IDX_W(IDX_W), .MSG_LEN(MSG_LEN)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .done        (done),
  .workWrEn    (workWrEn),
  .plainWrEn   (plainWrEn),
  .plainAddr   (plainAddr),
  .plainWrData (plainWrData),
  .byteValid   (byteValid),
  .byteOut     (byteOut)
);

// File: tb/rc4x_engine_tb_top.sv
module rc4x_engine_tb_top;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN, start, done;
  logic [7:0] workAddr, workWrData, workRdData, cipherRdData, plainWrData, byteOut;
  logic [4:0] cipherAddr, plainAddr;
  logic       workWrEn, plainWrEn, byteValid;

  rc4x_engine dut_i (
    .clk(clk), .rstN(rstN), .start(start), .done(done),
    .workAddr(workAddr), .workWrData(workWrData), .workWrEn(workWrEn),
    .workRdData(workRdData), .cipherAddr(cipherAddr), .cipherRdData(cipherRdData),
    .plainAddr(plainAddr), .plainWrData(plainWrData), .plainWrEn(plainWrEn),
    .byteValid(byteValid), .byteOut(byteOut)
  );

  logic [7:0] workMem [256];
  logic [7:0] cipherMem [32];
  logic [7:0] plainMem [32];
  logic [7:0] sM [256];
  logic [7:0] expPlain [32];
  logic [7:0] streamBuf [32];
  int streamCnt;
  int checks = 0;
  int errors = 0;

  always @(posedge clk) begin
    if (workWrEn) workMem[workAddr] <= workWrData;
    else          workRdData <= workMem[workAddr];
    cipherRdData <= cipherMem[cipherAddr];
    if (plainWrEn) plainMem[plainAddr] <= plainWrData;
  end

  always @(negedge clk) begin
    if (byteValid) begin
      if (streamCnt < 32) streamBuf[streamCnt] = byteOut;
      streamCnt = streamCnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic loadIdentity();
    for (int n = 0; n < 256; n++) workMem[n] = 8'(n);
  endtask

  task automatic loadKeySchedule(input logic [23:0] key);
    logic [7:0] kb [3];
    logic [7:0] j, t;
    kb[0] = key[23:16]; kb[1] = key[15:8]; kb[2] = key[7:0];
    loadIdentity();
    j = 8'd0;
    for (int n = 0; n < 256; n++) begin
      j = j + workMem[n] + kb[n % 3];
      t = workMem[n]; workMem[n] = workMem[j]; workMem[j] = t;
    end
  endtask

  task automatic loadRandomPerm();
    logic [7:0] t;
    int r;
    loadIdentity();
    for (int n = 255; n > 0; n--) begin
      r = $urandom_range(n, 0);
      t = workMem[n]; workMem[n] = workMem[r]; workMem[r] = t;
    end
  endtask

  task automatic loadCipher();
    for (int n = 0; n < 32; n++) cipherMem[n] = 8'($urandom);
  endtask

  task automatic modelRun();
    logic [7:0] i, j, t, sumI;
    for (int n = 0; n < 256; n++) sM[n] = workMem[n];
    i = 8'd0; j = 8'd0;
    for (int k = 0; k < 32; k++) begin
      i = i + 8'd1;
      j = j + sM[i];
      t = sM[i]; sM[i] = sM[j]; sM[j] = t;
      sumI = sM[i] + sM[j];
      expPlain[k] = sM[sumI] ^ cipherMem[k];
    end
  endtask

  task automatic runAndCheck(input string req, input bit midStart);
    int waitCnt, bad, firstA, firstE;
    modelRun();
    for (int n = 0; n < 32; n++) plainMem[n] = 8'hxx;
    streamCnt = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(done == 1'b0, "R6 done cleared by start", int'(done), 0);
    if (midStart) begin
      repeat (47) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    waitCnt = 0;
    while (!done && waitCnt < 5000) begin
      @(negedge clk);
      waitCnt++;
    end
    check(done == 1'b1, {req, " R6 done reached"}, int'(done), 1);
    check(streamCnt == 32, {req, " R4 write count"}, streamCnt, 32);
    bad = 0; firstA = 0; firstE = 0;
    for (int n = 0; n < 32; n++)
      if (plainMem[n] !== expPlain[n]) begin
        if (bad == 0) begin firstA = int'(plainMem[n]); firstE = int'(expPlain[n]); end
        bad++;
      end
    check(bad == 0, {req, " R3 R4 result RAM"}, firstA, firstE);
    bad = 0;
    for (int n = 0; n < 32; n++)
      if (streamBuf[n] !== expPlain[n]) begin
        if (bad == 0) begin firstA = int'(streamBuf[n]); firstE = int'(expPlain[n]); end
        bad++;
      end
    check(bad == 0, {req, " R8 side stream"}, firstA, firstE);
    bad = 0;
    for (int n = 0; n < 256; n++)
      if (workMem[n] !== sM[n]) begin
        if (bad == 0) begin firstA = int'(workMem[n]); firstE = int'(sM[n]); end
        bad++;
      end
    check(bad == 0, {req, " R5 working RAM"}, firstA, firstE);
    bad = 0;
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      if (!done || workWrEn || plainWrEn) bad++;
    end
    check(bad == 0, {req, " R6 done held and quiet"}, bad, 0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0;
    start = 1'b0;
    streamCnt = 0;
    loadIdentity();
    loadCipher();
    repeat (3) @(negedge clk);
    // R1: outputs quiet under reset
    check(!done && !workWrEn && !plainWrEn && !byteValid, "R1 in reset",
          {done, workWrEn, plainWrEn, byteValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!done && !workWrEn && !plainWrEn && !byteValid, "R1 after reset",
          {done, workWrEn, plainWrEn, byteValid}, 0);

    // R9: key schedule of key 0x000249
    loadKeySchedule(24'h000249);
    loadCipher();
    runAndCheck("R9", 1'b0);

    // R2: rerun over the RAM left behind; i and j must restart at 0
    runAndCheck("R2", 1'b0);

    // R10: identity permutation, self-exchange on the first step
    loadIdentity();
    loadCipher();
    runAndCheck("R10", 1'b0);

    // R3: random permutations and ciphertexts
    for (int t = 0; t < 4; t++) begin
      loadRandomPerm();
      loadCipher();
      runAndCheck("R3", 1'b0);
    end

    // R7: start pulsed mid-run is ignored
    loadRandomPerm();
    loadCipher();
    runAndCheck("R7", 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule